// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running time of day for packet timestamping. The time is a 48-bit count of seconds and a 30-bit count of nanoseconds. On every clock the nanosecond count grows by a programmed whole-nanosecond step. A 24-bit fractional step runs alongside it, and each overflow of the fraction adds one more nanosecond. When the nanosecond count reaches one billion, it wraps and one second is carried into the seconds count.

Software controls the counter through a single-cycle write port. Each write carries a 3-bit register select and a 32-bit data word. The registers are:
- the two halves of the seconds count;
- the nanosecond count;
- the whole-nanosecond step;
- the fractional step;
- a one-shot signed offset.

Writes that must take effect together are staged. The upper seconds half waits for the lower half. The fractional step waits for the whole-nanosecond step. The current time is always visible on two output buses.

Top module: `ptp_tod_timer`

## Requirements
- R1: After reset, timeSec and timeNs are zero, both steps are zero, the staged upper seconds half is zero, and the fraction accumulator is zero.
- R2: A write with select 0 stores data[15:0] as a staged upper seconds half and leaves timeSec unchanged. A later write with select 1 loads timeSec with {staged half, data[31:0]} in one cycle.
- R3: On each cycle that has no time write and no offset, timeNs grows by the active whole step plus the carry out of a 24-bit fraction accumulator, which adds the active fractional step.
- R4: In a write with select 4, data[15:0] give fraction bits [23:8] and data[31:24] give fraction bits [7:0].
- R5: A fractional-step write is only held pending. A write with select 3 loads the whole step from data[7:0] and activates the pending fraction. Both are used from the following cycle on.
- R6: When the stepped nanosecond count reaches 1,000,000,000, 1,000,000,000 is subtracted from it and timeSec grows by one, with the carry running across all 48 bits.
- R7: With both active steps zero, the time does not change.
- R8: A write with select 5 applies a one-shot offset. Bit 31 is the sign (set means subtract), and bits [29:0] are the magnitude. Crossing a second boundary borrows from, or carries into, timeSec.
- R9: A cycle with a write of select 1, 2 or 5 adds no step, and the fraction accumulator holds. A write with select 2 loads timeNs from data[29:0].
- R10: Writes with select 6 or 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 3 | Register select |
| wrData | input | 32 | Write data |
| timeSec | output | 48 | Current seconds |
| timeNs | output | 30 | Current nanoseconds, always below one billion |

## Verification
The assertions assume two things about the write port. Every nanosecond value loaded with select 2 is below one billion, and every offset magnitude is also below one billion. Under those limits a single wrap or borrow is always enough, so timeNs can never leave its legal range. The stimulus writes only such values. It reaches the wrap and borrow cases by placing the nanosecond count a few steps, or a small offset, away from a boundary. It freezes the counter with zero steps before checking the offsets, so that each expected value is exact.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NS_PER_SEC = 1_000_000_000;

  localparam logic [2:0] REG_SEC_HI  = 3'd0;
  localparam logic [2:0] REG_SEC_LO  = 3'd1;
  localparam logic [2:0] REG_NS      = 3'd2;
  localparam logic [2:0] REG_INC_NS  = 3'd3;
  localparam logic [2:0] REG_INC_SUB = 3'd4;
  localparam logic [2:0] REG_ADJ     = 3'd5;

  typedef struct packed {
    logic loadSec;
    logic loadNs;
    logic applyAdj;
    logic adjNeg;
  } todStrobe_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output todStrobe_t        strb,
  output logic [SEC_W-1:0]  secLoadVal,
  output logic [NS_W-1:0]   nsLoadVal,
  output logic [NS_W-1:0]   adjMag,
  output logic [INC_W-1:0]  incNs,
  output logic [FRAC_W-1:0] incFrac
);
  localparam int HI_W      = SEC_W - DATA_W;
  localparam int FRAC_HI_W = DATA_W / 2;
  localparam int FRAC_LO_W = FRAC_W - FRAC_HI_W;

  logic [HI_W-1:0]   secHiQ;
  logic [FRAC_W-1:0] fracPendQ;
  logic [INC_W-1:0]  incNsQ;
  logic [FRAC_W-1:0] incFracQ;
  logic              hitSecHi, hitSecLo, hitNs, hitInc, hitSub, hitAdj;
  logic [FRAC_W-1:0] fracWord;

  always_comb begin
    hitSecHi = wrEn && (wrAddr == REG_SEC_HI);
    hitSecLo = wrEn && (wrAddr == REG_SEC_LO);
    hitNs    = wrEn && (wrAddr == REG_NS);
    hitInc   = wrEn && (wrAddr == REG_INC_NS);
    hitSub   = wrEn && (wrAddr == REG_INC_SUB);
    hitAdj   = wrEn && (wrAddr == REG_ADJ);
    // upper fraction in low half-word, lowest fraction byte in top byte
    fracWord = {wrData[FRAC_HI_W-1:0], wrData[DATA_W-1 -: FRAC_LO_W]};
  end

  always_comb begin
    strb.loadSec  = hitSecLo;
    strb.loadNs   = hitNs;
    strb.applyAdj = hitAdj;
    strb.adjNeg   = wrData[DATA_W-1];
    secLoadVal    = {secHiQ, wrData};
    nsLoadVal     = wrData[NS_W-1:0];
    adjMag        = wrData[NS_W-1:0];
    incNs         = incNsQ;
    incFrac       = incFracQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secHiQ    <= '0;
      fracPendQ <= '0;
      incNsQ    <= '0;
      incFracQ  <= '0;
    end else begin
      if (hitSecHi) secHiQ <= wrData[HI_W-1:0];
      if (hitSub)   fracPendQ <= fracWord;
      if (hitInc) begin
        incNsQ   <= wrData[INC_W-1:0];
        incFracQ <= fracPendQ;
      end
    end
  end
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int SEC_W   = 48,
  parameter int NS_W    = 30,
  parameter int INC_W   = 8,
  parameter int FRAC_W  = 24,
  parameter int NS_WRAP = NS_PER_SEC
) (
  input  logic              clk,
  input  logic              rstN,
  input  todStrobe_t        strb,
  input  logic [SEC_W-1:0]  secLoadVal,
  input  logic [NS_W-1:0]   nsLoadVal,
  input  logic [NS_W-1:0]   adjMag,
  input  logic [INC_W-1:0]  incNs,
  input  logic [FRAC_W-1:0] incFrac,
  output logic [SEC_W-1:0]  timeSec,
  output logic [NS_W-1:0]   timeNs
);
  localparam int EW = NS_W + 1;
  localparam logic [EW-1:0] WRAP = EW'(NS_WRAP);

  logic [SEC_W-1:0]  secQ, secNxt;
  logic [NS_W-1:0]   nsQ, nsNxt;
  logic [FRAC_W-1:0] fracQ, fracNxt;
  logic [FRAC_W:0]   fracSum;
  logic [EW-1:0]     stepNs, addNs, subNs, nsExt, magExt;
  logic              borrow;

  always_comb begin
    nsExt   = {1'b0, nsQ};
    magExt  = {1'b0, adjMag};
    fracSum = {1'b0, fracQ} + {1'b0, incFrac};
    stepNs  = nsExt + EW'(incNs) + EW'(fracSum[FRAC_W]);
    addNs   = nsExt + magExt;
    borrow  = magExt > nsExt;
    subNs   = borrow ? (nsExt + WRAP - magExt) : (nsExt - magExt);

    secNxt  = secQ;
    nsNxt   = nsQ;
    fracNxt = fracQ;
    if (strb.loadSec) begin
      secNxt = secLoadVal;
    end else if (strb.loadNs) begin
      nsNxt = nsLoadVal;
    end else if (strb.applyAdj) begin
      if (strb.adjNeg) begin
        nsNxt = subNs[NS_W-1:0];
        if (borrow) secNxt = secQ - SEC_W'(1);
      end else if (addNs >= WRAP) begin
        nsNxt  = NS_W'(addNs - WRAP);
        secNxt = secQ + SEC_W'(1);
      end else begin
        nsNxt = addNs[NS_W-1:0];
      end
    end else begin
      fracNxt = fracSum[FRAC_W-1:0];
      if (stepNs >= WRAP) begin
        nsNxt  = NS_W'(stepNs - WRAP);
        secNxt = secQ + SEC_W'(1);
      end else begin
        nsNxt = stepNs[NS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ  <= '0;
      nsQ   <= '0;
      fracQ <= '0;
    end else begin
      secQ  <= secNxt;
      nsQ   <= nsNxt;
      fracQ <= fracNxt;
    end
  end

  assign timeSec = secQ;
  assign timeNs  = nsQ;
endmodule

// File: rtl/ptp_tod_timer.sv
module ptp_tod_timer
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int INC_W  = 8,
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [SEC_W-1:0]  timeSec,
  output logic [NS_W-1:0]   timeNs
);
  todStrobe_t        strb;
  logic [SEC_W-1:0]  secLoadVal;
  logic [NS_W-1:0]   nsLoadVal, adjMag;
  logic [INC_W-1:0]  incNs;
  logic [FRAC_W-1:0] incFrac;

  tod_ctrl #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .FRAC_W(FRAC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .secLoadVal(secLoadVal), .nsLoadVal(nsLoadVal),
    .adjMag(adjMag), .incNs(incNs), .incFrac(incFrac)
  );

  tod_datapath #(
    .SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W), .FRAC_W(FRAC_W), .NS_WRAP(NS_PER_SEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .secLoadVal(secLoadVal),
    .nsLoadVal(nsLoadVal), .adjMag(adjMag), .incNs(incNs), .incFrac(incFrac),
    .timeSec(timeSec), .timeNs(timeNs)
  );
endmodule

// File: rtl/ptp_tod_timer_chk.sv
module ptp_tod_timer_chk
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [SEC_W-1:0]  timeSec,
  input logic [NS_W-1:0]   timeNs
);
  localparam logic [NS_W:0] WRAP = (NS_W+1)'(NS_PER_SEC);

  // R6
  ns_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, timeNs} < WRAP);

  // R2
  sec_hi_staged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_SEC_HI) |=>
      (timeSec == $past(timeSec)) || (timeNs < $past(timeNs)));

  // R2
  sec_lo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_SEC_LO) |=> timeSec[DATA_W-1:0] == $past(wrData));

  // R9
  ns_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_NS) |=> timeNs == $past(wrData[NS_W-1:0]));

  // R8
  adj_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_ADJ && !wrData[DATA_W-1] &&
     ({1'b0, timeNs} + {1'b0, wrData[NS_W-1:0]} < WRAP)) |=>
      (timeNs == $past(timeNs) + $past(wrData[NS_W-1:0])) && $stable(timeSec));
endmodule

bind ptp_tod_timer ptp_tod_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .timeSec(timeSec), .timeNs(timeNs)
);

// File: tb/ptp_tod_timer_tb.sv
module ptp_tod_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [47:0] timeSec;
  logic [29:0] timeNs;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  typedef struct {
    logic [47:0] sec;
    logic [29:0] ns;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #5 clk = ~clk;

  ptp_tod_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timeSec(timeSec), .timeNs(timeNs)
  );

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbQ.size() != 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        testCount++;
        if (timeSec !== it.sec || timeNs !== it.ns) begin
          failCount++;
          $display("FAIL %s: sec=%h ns=%0d expected sec=%h ns=%0d",
                   it.tag, timeSec, timeNs, it.sec, it.ns);
        end
      end
    end
  end

  task automatic expect_t(input logic [47:0] sec, input logic [29:0] ns, input string tag);
    expItem_t it;
    it.sec = sec; it.ns = ns; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    expect_t(48'h0, 30'd0, "R1 reset state");
    idle(5);
    expect_t(48'h0, 30'd0, "R7 zero steps hold");

    wr(3'd0, 32'h0000_1234);
    expect_t(48'h0, 30'd0, "R2 upper half staged");
    wr(3'd1, 32'h89AB_CDEF);
    expect_t(48'h1234_89AB_CDEF, 30'd0, "R2 both halves loaded");
    wr(3'd2, 32'd100);
    expect_t(48'h1234_89AB_CDEF, 30'd100, "R9 ns load");

    wr(3'd4, 32'h0000_8000);   // fraction 0x800000 = one half
    idle(3);
    expect_t(48'h1234_89AB_CDEF, 30'd100, "R5 fraction pending");
    wr(3'd3, 32'd8);
    expect_t(48'h1234_89AB_CDEF, 30'd100, "R5 step used from next cycle");
    idle(4);
    expect_t(48'h1234_89AB_CDEF, 30'd134, "R3 step 8.5 ns");

    wr(3'd4, 32'h0100_FFFF);   // fraction 0xFFFF01
    wr(3'd3, 32'd0);
    expect_t(48'h1234_89AB_CDEF, 30'd151, "R5 old step during commit");
    idle(10);
    expect_t(48'h1234_89AB_CDEF, 30'd160, "R4 fraction field order");

    wr(3'd4, 32'h0);
    wr(3'd3, 32'd8);
    expect_t(48'h1234_89AB_CDEF, 30'd162, "R3 carry only steps");
    wr(3'd2, 32'd999_999_990);
    expect_t(48'h1234_89AB_CDEF, 30'd999_999_990, "R9 no step on load");
    idle(1);
    expect_t(48'h1234_89AB_CDEF, 30'd999_999_998, "R3 step 8");
    idle(1);
    expect_t(48'h1234_89AB_CDF0, 30'd6, "R6 wrap into seconds");

    wr(3'd0, 32'h0000_0001);
    wr(3'd1, 32'hFFFF_FFFF);
    expect_t(48'h0001_FFFF_FFFF, 30'd14, "R9 no step on seconds load");
    wr(3'd2, 32'd999_999_995);
    idle(1);
    expect_t(48'h0002_0000_0000, 30'd3, "R6 carry across 32 bits");

    wr(3'd3, 32'd0);
    idle(5);
    expect_t(48'h0002_0000_0000, 30'd11, "R7 frozen");

    wr(3'd2, 32'd500);
    wr(3'd5, 32'd300);
    expect_t(48'h0002_0000_0000, 30'd800, "R8 add");
    wr(3'd5, 32'h8000_00C8);
    expect_t(48'h0002_0000_0000, 30'd600, "R8 subtract");
    wr(3'd5, 32'h8000_02BC);
    expect_t(48'h0001_FFFF_FFFF, 30'd999_999_900, "R8 borrow");
    wr(3'd5, 32'd150);
    expect_t(48'h0002_0000_0000, 30'd50, "R8 carry");

    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0000_00FF);
    idle(3);
    expect_t(48'h0002_0000_0000, 30'd50, "R10 unused selects");

    wr(3'd0, 32'h0000_ABCD);
    expect_t(48'h0002_0000_0000, 30'd50, "R2 staged again");
    wr(3'd1, 32'h0);
    expect_t(48'hABCD_0000_0000, 30'd50, "R2 load with new half");

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule